// File: doc/BRIEF.md
# Vectored Interrupt Mask Controller

This block sits in front of a small 8-bit processor core and turns three hardware interrupt lines into a single request with a restart address. Each line has its own mask bit. One global enable gates all three. The core learns which line to serve from an 8-bit restart address that the block derives from the highest-priority line that is both pending and unmasked. The top line (index 2) is captured on its rising edge and held until it is served or cleared. The two lower lines are level-sensitive and follow their inputs.

Software controls the block through three paths. A set-mask word loads new mask bits when its load-enable bit is set, and it can also discard a held edge request. Two strobes set and clear the global enable. A read-back word shows the pending state of every line, whether or not it is masked, together with the global enable and the mask bits. When the core acknowledges a request, the global enable drops, so no second request reaches the core until software enables interrupts again.

Top module: `vint_ctrl`

## Requirements
- R1: After reset every mask bit is 1 (masked), the global enable is 0, no edge request is held, `int_req_o` is 0, `vector_o` is 00h and `status_o` reads 07h.
- R2: A write on `mask_wr_i` loads `mask_word_i[2:0]` into the mask bits (1 = masked) only when `mask_word_i[3]` is 1. When bit 3 is 0 the mask bits keep their value.
- R3: A write on `mask_wr_i` with `mask_word_i[4]` = 1 discards the held edge request of line 2 on the next clock.
- R4: A rising edge on `irq_i[2]` sets a held request on the next clock. The request stays after the input falls, stays visible while masked, and is not set again by an input that simply stays high.
- R5: Lines 0 and 1 are level-sensitive: their pending bits follow `irq_i[0]` and `irq_i[1]` and are not held.
- R6: `status_o` = {0, pending[2:0], global enable, mask[2:0]}. Bits 6:4 are the pending lines, bit 3 is the global enable and bits 2:0 are the masks.
- R7: `int_req_o` is 1 exactly when the global enable is 1 and at least one pending line has a mask bit of 0.
- R8: Priority is 2 over 1 over 0. `vector_o` is 3Ch for line 2, 34h for line 1 and 2Ch for line 0, and it is 00h while `int_req_o` is 0.
- R9: `int_ack_i` while `int_req_o` is 1 clears the global enable on that clock. If line 2 was the line selected, its held request is also cleared. Level lines are not affected.
- R10: `gie_set_i` sets the global enable and `gie_clr_i` clears it. When strobes coincide, an acknowledge beats a clear, and a clear beats a set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | 3 | Hardware interrupt lines; index 2 edge, 1 and 0 level |
| gie_set_i | input | 1 | Strobe: set global enable |
| gie_clr_i | input | 1 | Strobe: clear global enable |
| mask_wr_i | input | 1 | Strobe: apply set-mask word |
| mask_word_i | input | 8 | Set-mask word: [2:0] masks, [3] load enable, [4] discard edge request |
| int_ack_i | input | 1 | Acknowledge from the core |
| int_req_o | output | 1 | Interrupt request to the core |
| vector_o | output | 8 | Restart address of the selected line |
| status_o | output | 8 | Read-back word |

## Verification
A table of mask, level-input and enable combinations tests the selection logic. It separates the cases where the mask blocks a pending line, where the global enable alone blocks it, and where two pending lines compete and the higher one must win. Directed sequences then drive the edge line. They show that a held request survives the input falling, that an input held high does not set the request again, and that the request stays visible while masked. They also show that the discard bit, an acknowledge, and coinciding enable strobes each change only the state they are meant to change.

// File: rtl/imc_pkg.sv
package imc_pkg;
   localparam int IMC_SRC_DEF  = 3;
   localparam int IMC_WORD_DEF = 8;
   localparam int IMC_BASE_DEF = 'h2C;
   localparam int IMC_STEP_DEF = 8;

   function automatic int imc_vec_of(input int base, input int step, input int idx);
      return base + step * idx;
   endfunction
endpackage

// File: rtl/imc_edge_src.sv
module imc_edge_src (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   input  logic clr_i,
   output logic pend_o
);
   logic prev_q;
   logic lat_q;
   logic rise;

   assign rise   = raw_i & ~prev_q;
   assign pend_o = lat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         lat_q  <= 1'b0;
      end else begin
         prev_q <= raw_i;
         if (rise)       lat_q <= 1'b1;
         else if (clr_i) lat_q <= 1'b0;
      end
   end

   // R4: a held request stays until cleared
   p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_q && !clr_i) |=> lat_q);
   // R3, R9: a clear with no new edge empties the latch
   p_clear_works_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !rise) |=> !pend_o);
endmodule

// File: rtl/imc_gate.sv
module imc_gate #(
   parameter int N_SRC = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mask_wr_i,
   input  logic             mask_en_i,
   input  logic [N_SRC-1:0] mask_new_i,
   input  logic             gie_set_i,
   input  logic             gie_clr_i,
   input  logic             ack_fire_i,
   output logic [N_SRC-1:0] mask_o,
   output logic             gie_o
);
   logic [N_SRC-1:0] mask_q;
   logic             gie_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '1;
         gie_q  <= 1'b0;
      end else begin
         if (mask_wr_i && mask_en_i) mask_q <= mask_new_i;
         if (ack_fire_i)     gie_q <= 1'b0;
         else if (gie_clr_i) gie_q <= 1'b0;
         else if (gie_set_i) gie_q <= 1'b1;
      end
   end

   assign mask_o = mask_q;
   assign gie_o  = gie_q;

   p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(mask_wr_i && mask_en_i) |=> $stable(mask_q));
   p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_wr_i && mask_en_i) |=> (mask_q == $past(mask_new_i)));
   p_gie_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!gie_set_i && !gie_clr_i && !ack_fire_i) |=> $stable(gie_q));
   p_ack_drops_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ack_fire_i |=> !gie_q);
endmodule

// File: rtl/imc_prio.sv
module imc_prio
   import imc_pkg::*;
#(
   parameter int N_SRC    = 3,
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 'h2C,
   parameter int VEC_STEP = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] pend_i,
   input  logic [N_SRC-1:0] mask_i,
   input  logic             gie_i,
   output logic [N_SRC-1:0] grant_o,
   output logic             req_o,
   output logic [VEC_W-1:0] vec_o
);
   logic [N_SRC-1:0] live;

   assign live = pend_i & ~mask_i;

   always_comb begin
      grant_o = '0;
      vec_o   = '0;
      if (gie_i) begin
         for (int i = 0; i < N_SRC; i++) begin
            if (live[i]) begin
               grant_o    = '0;
               grant_o[i] = 1'b1;
               vec_o      = VEC_W'(imc_vec_of(VEC_BASE, VEC_STEP, i));
            end
         end
      end
   end

   assign req_o = gie_i & (|live);

   p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));
   p_grant_with_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_o == ($countones(grant_o) == 1));
endmodule

// File: rtl/vint_ctrl.sv
module vint_ctrl
   import imc_pkg::*;
#(
   parameter int N_SRC     = IMC_SRC_DEF,
   parameter int WORD_W    = IMC_WORD_DEF,
   parameter int VEC_BASE  = IMC_BASE_DEF,
   parameter int VEC_STEP  = IMC_STEP_DEF,
   parameter int EDGE_MASK = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  irq_i,
   input  logic              gie_set_i,
   input  logic              gie_clr_i,
   input  logic              mask_wr_i,
   input  logic [WORD_W-1:0] mask_word_i,
   input  logic              int_ack_i,
   output logic              int_req_o,
   output logic [WORD_W-1:0] vector_o,
   output logic [WORD_W-1:0] status_o
);
   localparam int GIE_BIT  = N_SRC;
   localparam int PEND_LO  = N_SRC + 1;
   localparam int MEN_BIT  = N_SRC;
   localparam int DROP_BIT = N_SRC + 1;
   localparam int VEC_TOP  = VEC_BASE + VEC_STEP * (N_SRC - 1);

   if (2 * N_SRC + 1 > WORD_W) begin : g_bad_word
      $error("read-back word too narrow for N_SRC");
   end
   if (VEC_TOP >= (1 << WORD_W)) begin : g_bad_vec
      $error("restart address does not fit the word");
   end

   logic [N_SRC-1:0] pend;
   logic [N_SRC-1:0] mask;
   logic [N_SRC-1:0] grant;
   logic             gie;
   logic             ack_fire;
   logic             sw_drop;

   assign ack_fire = int_ack_i & int_req_o;
   assign sw_drop  = mask_wr_i & mask_word_i[DROP_BIT];

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      if (EDGE_MASK[i]) begin : g_edge
         imc_edge_src u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (irq_i[i]),
            .clr_i  (sw_drop | (ack_fire & grant[i])),
            .pend_o (pend[i])
         );
      end else begin : g_level
         assign pend[i] = irq_i[i];
      end
   end

   imc_gate #(.N_SRC(N_SRC)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .mask_wr_i  (mask_wr_i),
      .mask_en_i  (mask_word_i[MEN_BIT]),
      .mask_new_i (mask_word_i[N_SRC-1:0]),
      .gie_set_i  (gie_set_i),
      .gie_clr_i  (gie_clr_i),
      .ack_fire_i (ack_fire),
      .mask_o     (mask),
      .gie_o      (gie)
   );

   imc_prio #(
      .N_SRC    (N_SRC),
      .VEC_W    (WORD_W),
      .VEC_BASE (VEC_BASE),
      .VEC_STEP (VEC_STEP)
   ) u_prio (
      .clk     (clk),
      .rst_n   (rst_n),
      .pend_i  (pend),
      .mask_i  (mask),
      .gie_i   (gie),
      .grant_o (grant),
      .req_o   (int_req_o),
      .vec_o   (vector_o)
   );

   always_comb begin
      status_o                          = '0;
      status_o[N_SRC-1:0]               = mask;
      status_o[GIE_BIT]                 = gie;
      status_o[PEND_LO +: N_SRC]        = pend;
   end

   p_ack_silences_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ack_fire |=> !int_req_o);
   p_vec_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !int_req_o |-> (vector_o == '0));
endmodule

// File: tb/vint_ctrl_bench.sv
module vint_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [2:0] irq_i;
   logic       gie_set_i, gie_clr_i, mask_wr_i, int_ack_i;
   logic [7:0] mask_word_i;
   logic       int_req_o;
   logic [7:0] vector_o, status_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   vint_ctrl u_vint_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_i(irq_i),
      .gie_set_i(gie_set_i), .gie_clr_i(gie_clr_i),
      .mask_wr_i(mask_wr_i), .mask_word_i(mask_word_i),
      .int_ack_i(int_ack_i), .int_req_o(int_req_o),
      .vector_o(vector_o), .status_o(status_o)
   );

   // [15:14] level lines 1,0  [13:11] mask  [10] gie  [8] req  [7:0] vector
   localparam logic [15:0] TBL [10] = '{
      {2'b01, 3'b111, 1'b1, 1'b0, 1'b0, 8'h00},
      {2'b01, 3'b110, 1'b1, 1'b0, 1'b1, 8'h2C},
      {2'b11, 3'b100, 1'b1, 1'b0, 1'b1, 8'h34},
      {2'b11, 3'b101, 1'b1, 1'b0, 1'b1, 8'h34},
      {2'b11, 3'b110, 1'b0, 1'b0, 1'b0, 8'h00},
      {2'b10, 3'b101, 1'b1, 1'b0, 1'b1, 8'h34},
      {2'b10, 3'b010, 1'b1, 1'b0, 1'b0, 8'h00},
      {2'b00, 3'b000, 1'b1, 1'b0, 1'b0, 8'h00},
      {2'b11, 3'b011, 1'b1, 1'b0, 1'b0, 8'h00},
      {2'b01, 3'b000, 1'b1, 1'b0, 1'b1, 8'h2C}
   };

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
      chk(act == exp, req, act, exp);
   endtask

   task automatic strobes_off();
      gie_set_i = 0; gie_clr_i = 0; mask_wr_i = 0; int_ack_i = 0; mask_word_i = 8'h00;
   endtask

   initial begin
      rst_n = 0; irq_i = 3'b000;
      strobes_off();
      tick(); tick();
      rst_n = 1;
      // R1, R6: reset state
      chk8("R1 status", status_o, 8'h07);
      chk8("R1 req", {7'b0, int_req_o}, 8'h00);
      chk8("R1 vector", vector_o, 8'h00);

      // R2 R5 R6 R7 R8: table of combinations
      for (int k = 0; k < 10; k++) begin
         logic [15:0] e;
         e = TBL[k];
         mask_wr_i   = 1;
         mask_word_i = {4'b0000, 1'b1, e[13:11]};
         gie_set_i   = e[10];
         gie_clr_i   = !e[10];
         irq_i       = {1'b0, e[15:14]};
         tick();
         strobes_off();
         chk8("R7 req", {7'b0, int_req_o}, {7'b0, e[8]});
         chk8("R8 vector", vector_o, e[7:0]);
         chk8("R6 status", status_o, {2'b00, e[15:14], e[10], e[13:11]});
      end

      // open all masks, enable, lines low
      irq_i = 3'b000; mask_wr_i = 1; mask_word_i = 8'h08; gie_set_i = 1;
      tick(); strobes_off();

      // R4: rising edge on line 2 is held
      irq_i[2] = 1; tick();
      chk8("R4 status after edge", status_o, 8'h48);
      chk8("R8 vector line2", vector_o, 8'h3C);
      irq_i[2] = 0; irq_i[0] = 1; tick();
      chk8("R4 held after fall", status_o, 8'h58);
      chk8("R8 line2 beats line0", vector_o, 8'h3C);

      // R9: acknowledge clears enable and line 2, level line stays
      int_ack_i = 1; tick(); strobes_off();
      chk8("R9 status after ack", status_o, 8'h10);
      chk8("R9 req after ack", {7'b0, int_req_o}, 8'h00);

      // R10: enable again
      gie_set_i = 1; tick(); strobes_off();
      chk8("R10 set", status_o, 8'h18);
      chk8("R8 vector line0", vector_o, 8'h2C);
      int_ack_i = 1; gie_set_i = 1; tick(); strobes_off();
      chk8("R10 ack beats set", status_o, 8'h10);
      gie_set_i = 1; tick(); strobes_off();
      gie_set_i = 1; gie_clr_i = 1; tick(); strobes_off();
      chk8("R10 clear beats set", status_o, 8'h10);

      // R4 R7: edge while masked is visible but raises no request
      irq_i[0] = 0; mask_wr_i = 1; mask_word_i = 8'h0C; gie_set_i = 1; irq_i[2] = 1;
      tick(); strobes_off();
      chk8("R4 pending while masked", status_o, 8'h4C);
      chk8("R7 masked no req", {7'b0, int_req_o}, 8'h00);

      // R3 R2: discard bit clears line 2, mask unchanged with load enable 0
      mask_wr_i = 1; mask_word_i = 8'h10; tick(); strobes_off();
      chk8("R3 discard / R2 mask kept", status_o, 8'h0C);
      tick();
      chk8("R4 steady high no relatch", status_o, 8'h0C);

      // R4 new edge, then unmask
      irq_i[2] = 0; tick(); irq_i[2] = 1; tick();
      chk8("R4 second edge", status_o, 8'h4C);
      mask_wr_i = 1; mask_word_i = 8'h08; tick(); strobes_off();
      chk8("R7 req after unmask", {7'b0, int_req_o}, 8'h01);
      chk8("R8 vector after unmask", vector_o, 8'h3C);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule